// File: doc/BRIEF.md
# Self-Timed Byte Memory Bus Emulator

This block stands in for a byte-wide nonvolatile memory on an SRAM-style asynchronous bus. The bus has active-low chip enable, output enable and write enable, an address and a data path that is split into input, output and output-enable. The three strobes are brought into the clock domain through two flip-flops, and edges are found on the synchronized copies. Reads return the stored byte. A write strobe pulse arms a write: the address is taken at the start of the pulse and the data at its end. A self-timed program cycle then runs with no further bus activity. It first clears the location and commits the new byte when its timer runs out.

While the program cycle runs, a ready line is pulled low. Any read during that time returns a polling word: bit 7 holds the inverse of the byte being written and bits 6:0 are zero. Writes are refused while the digital supply-ok input is low, during a power-on lockout that follows reset or a return of supply-ok, and when output enable is low at the start of the strobe. A write strobe that arrives while a program cycle is running is ignored.

Top module: `nvm_bus_emu`

## Requirements
- R1: With synchronized chip enable low, output enable low and write enable high, data_oe_o is 1 and data_o carries the byte stored at addr_i. The enable settles two clock edges after the pins change.
- R2: data_oe_o is 0 whenever synchronized chip enable or output enable is high.
- R3: Write-enable-controlled write: with chip enable low, a write enable pulse takes addr_i when the pulse starts and data_i when it ends. After the program cycle, that address reads back the new byte.
- R4: Chip-enable-controlled write: with write enable low, a chip enable pulse writes in the same way as R3.
- R5: ready_o is driven low for exactly WR_CYCLES clock cycles per accepted write, starting after the strobe ends, and is high otherwise. The array changes only during a write.
- R6: While ready_o is low, a read of any address returns the polling word: bit 7 is the inverse of bit 7 of the byte being written and bits 6:0 are 0. After the cycle ends, reads return true data.
- R7: While supply_ok_i is 0, no write is accepted. ready_o stays high and the array is unchanged.
- R8: For POR_CYCLES cycles after reset, and after each return of supply_ok_i to 1, writes are refused.
- R9: If output enable is low when the write strobe starts, the write is refused.
- R10: A write strobe that starts during a program cycle is ignored. Its address keeps its old contents and the running cycle keeps its length.
- R11: After reset, ready_o is 1, data_oe_o is 0 and every location reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply valid, synchronous to clk_i |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data or polling word |
| data_oe_o | output | 1 | Data output drive enable |
| ready_o | output | 1 | 0 = pulling the shared ready line low (write in progress), 1 = released |

## Verification
The checks assume that each strobe level lasts at least three clocks. They also assume that addr_i is stable from before the strobe starts until two edges after it, that data_i is held at least three clocks after the strobe ends, and that supply_ok_i is already synchronous to clk_i. The stimulus keeps to these limits: it moves pins only on falling clock edges, holds every strobe level for four clocks, and keeps address and data steady for the whole write task. Random writes, reads and inhibited attempts are compared against a byte model kept in the bench.

// File: rtl/nvm_emu_pkg.sv
package nvm_emu_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PROG  = 2'd2
  } wr_state_e;

  // polling word: msb inverted, rest forced low
  function automatic logic [DW-1:0] poll_word(input logic [DW-1:0] d);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1] = ~d[DW-1];
    return w;
  endfunction
endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/nvm_por_timer.sv
module nvm_por_timer #(
  parameter int unsigned POR_CYCLES = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= CW'(POR_CYCLES);
    else if (!supply_ok_i) cnt <= CW'(POR_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign lock_o = (cnt != '0);

  a_r8_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> lock_o);
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_emu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned WR_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_s_i,
  input  logic              oe_s_i,
  input  logic              we_s_i,
  input  logic              supply_ok_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DW-1:0]     arr_wdata_o,
  output logic [DW-1:0]     poll_src_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  wr_state_e         state;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              wr_prev;
  logic              wr_act, wr_rise, wr_fall, allow;

  assign wr_act  = ~ce_s_i & ~we_s_i;
  assign wr_rise = wr_act & ~wr_prev;
  assign wr_fall = ~wr_act & wr_prev;
  assign allow   = oe_s_i & supply_ok_i & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wr_prev <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      unique case (state)
        ST_IDLE: if (wr_rise && allow) begin
          state  <= ST_ARMED;
          addr_q <= addr_i;
        end
        ST_ARMED: begin
          if (!supply_ok_i) state <= ST_IDLE;
          else if (wr_fall) begin
            state  <= ST_PROG;
            data_q <= data_i;
            cnt    <= CW'(WR_CYCLES - 1);
          end
        end
        ST_PROG: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // clear at cycle entry, program at cycle end
  assign arr_we_o    = ((state == ST_ARMED) && supply_ok_i && wr_fall) ||
                       ((state == ST_PROG) && (cnt == '0));
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = (state == ST_PROG) ? data_q : '0;
  assign busy_o      = (state == ST_PROG);
  assign poll_src_o  = data_q;

  a_r10_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PROG) |=> (state != ST_ARMED));
  a_r7_supply_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !supply_ok_i) |=> (state == ST_IDLE));
  a_r8_lock_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && lock_i) |=> (state == ST_IDLE));
  a_r9_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !oe_s_i) |=> (state == ST_IDLE));
  a_r3_commit_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (state != ST_IDLE));
  a_r5_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(cnt) == '0));
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_emu_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[i] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(i)))      mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/nvm_bus_emu.sv
module nvm_bus_emu
  import nvm_emu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned WR_CYCLES  = 64,
  parameter int unsigned POR_CYCLES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              ready_o
);
  logic [2:0]        strb_s;
  logic              ce_s, oe_s, we_s;
  logic              lock, busy, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DW-1:0]     arr_wdata, rdata, poll_src;

  nvm_sync #(.W(3), .RST_VAL(3'b111)) i_sync (
    .clk_i, .rst_ni,
    .d_i ({ce_ni, oe_ni, we_ni}),
    .q_o (strb_s)
  );
  assign {ce_s, oe_s, we_s} = strb_s;

  nvm_por_timer #(.POR_CYCLES(POR_CYCLES)) i_por (
    .clk_i, .rst_ni, .supply_ok_i, .lock_o(lock)
  );

  nvm_wr_ctrl #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) i_ctrl (
    .clk_i, .rst_ni,
    .ce_s_i(ce_s), .oe_s_i(oe_s), .we_s_i(we_s),
    .supply_ok_i, .lock_i(lock),
    .addr_i, .data_i,
    .busy_o(busy), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .poll_src_o(poll_src)
  );

  nvm_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i, .rst_ni,
    .we_i(arr_we), .waddr_i(arr_addr), .wdata_i(arr_wdata),
    .raddr_i(addr_i), .rdata_o(rdata)
  );

  assign data_oe_o = ~ce_s & ~oe_s & we_s;
  assign data_o    = busy ? poll_word(poll_src) : rdata;
  assign ready_o   = ~busy;

  a_r6_poll_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && data_oe_o) |-> (data_o[DW-2:0] == '0));
  a_r5_array_only_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we && arr_wdata != '0) |-> !ready_o);
endmodule

// File: tb/test_nvm_bus_emu.sv
module test_nvm_bus_emu;
  localparam int AW = 6, WRC = 64, PORC = 128, DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, sup = 1'b1;
  logic ce = 1'b1, oe = 1'b1, we = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic doe, rdy;
  int total = 0, bad = 0, lowcnt = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  nvm_bus_emu #(.ADDR_W(AW), .WR_CYCLES(WRC), .POR_CYCLES(PORC)) i_nvm_bus_emu (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup),
    .ce_ni(ce), .oe_ni(oe), .we_ni(we),
    .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .ready_o(rdy)
  );

  always @(negedge clk) if (rdy === 1'b0) lowcnt++;

  function automatic logic [7:0] exp_poll(input logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                          input bit ce_mode, input bit oe_low);
    @(negedge clk);
    addr = a; din = d; oe = oe_low ? 1'b0 : 1'b1;
    if (!ce_mode) begin
      ce = 1'b0; cyc(1); we = 1'b0; cyc(4); we = 1'b1; cyc(4); ce = 1'b1;
    end else begin
      we = 1'b0; cyc(1); ce = 1'b0; cyc(4); ce = 1'b1; cyc(4); we = 1'b1;
    end
    oe = 1'b1;
    cyc(1);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; ce = 1'b0; oe = 1'b0; we = 1'b1;
    cyc(3);
    chk({req, " oe"}, doe, 1'b1);
    chk(req, dout, exp);
    ce = 1'b1; oe = 1'b1;
    cyc(3);
  endtask

  task automatic wait_ready;
    int n = 0;
    while (rdy !== 1'b1 && n < 1000) begin
      cyc(1);
      n++;
    end
    chk("R5 ready release", n < 1000, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    cyc(3);
    chk("R11 ready", rdy, 1'b1);
    chk("R11 oe", doe, 1'b0);
    rst_n = 1'b1;

    // R8: writes refused during power-on lockout
    do_write(6'd5, 8'hA5, 1'b0, 1'b0);
    cyc(3);
    chk("R8 ready", rdy, 1'b1);
    rd_chk("R8 unchanged", 6'd5, 8'h00);
    rd_chk("R11 zero", 6'd40, 8'h00);
    cyc(PORC + 10);

    // R3 + R5 + R6 (bit7 set)
    lowcnt = 0;
    do_write(6'd5, 8'hA5, 1'b0, 1'b0);
    chk("R5 busy", rdy, 1'b0);
    rd_chk("R6 poll", 6'd9, exp_poll(8'hA5));
    wait_ready();
    chk("R5 length", lowcnt, WRC);
    rd_chk("R3 readback", 6'd5, 8'hA5);
    model[5] = 8'hA5;

    // R4 + R6 (bit7 clear)
    do_write(6'd6, 8'h3C, 1'b1, 1'b0);
    rd_chk("R6 poll", 6'd6, exp_poll(8'h3C));
    wait_ready();
    rd_chk("R4 readback", 6'd6, 8'h3C);
    rd_chk("R6 true data", 6'd5, 8'hA5);
    model[6] = 8'h3C;

    // R10: second strobe while busy
    lowcnt = 0;
    do_write(6'd7, 8'h11, 1'b0, 1'b0);
    do_write(6'd8, 8'h22, 1'b0, 1'b0);
    wait_ready();
    cyc(5);
    chk("R10 ready", rdy, 1'b1);
    chk("R10 length", lowcnt, WRC);
    rd_chk("R10 ignored", 6'd8, 8'h00);
    rd_chk("R10 first kept", 6'd7, 8'h11);
    model[7] = 8'h11;

    // R9: output enable low at strobe start
    do_write(6'd9, 8'h55, 1'b0, 1'b1);
    cyc(3);
    chk("R9 ready", rdy, 1'b1);
    rd_chk("R9 unchanged", 6'd9, 8'h00);

    // R2: no drive when chip enable or output enable high
    @(negedge clk); ce = 1'b0; oe = 1'b1; cyc(3);
    chk("R2 oe high", doe, 1'b0);
    ce = 1'b1; oe = 1'b0; cyc(3);
    chk("R2 ce high", doe, 1'b0);
    oe = 1'b1; cyc(3);

    // R7: supply low, then R8 relock
    sup = 1'b0;
    do_write(6'd10, 8'h77, 1'b1, 1'b0);
    cyc(3);
    chk("R7 ready", rdy, 1'b1);
    rd_chk("R7 unchanged", 6'd10, 8'h00);
    sup = 1'b1;
    do_write(6'd10, 8'h77, 1'b0, 1'b0);
    cyc(3);
    chk("R8 relock ready", rdy, 1'b1);
    rd_chk("R8 relock unchanged", 6'd10, 8'h00);
    cyc(PORC + 10);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      bit cm, inh;
      a = AW'($urandom % DEPTH);
      d = 8'($urandom);
      cm = 1'($urandom % 2);
      inh = ($urandom % 5) == 0;
      lowcnt = 0;
      do_write(a, d, cm, inh);
      if (!inh) begin
        model[a] = d;
        rd_chk("R6 poll rnd", AW'($urandom % DEPTH), exp_poll(d));
        wait_ready();
        chk("R5 length rnd", lowcnt, WRC);
      end else begin
        cyc(3);
        chk("R9 ready rnd", rdy, 1'b1);
      end
      begin
        logic [AW-1:0] ra;
        ra = ($urandom % 2) ? a : AW'($urandom % DEPTH);
        rd_chk("R1 read rnd", ra, model[ra]);
      end
    end

    report();
  end
endmodule